// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This block is the exception-entry stage of a small 32-bit in-order core. Every cycle it examines the flags that decode attaches to the executing instruction, the attributes of any special-register move, the outcome of the instruction-address translation, and the current machine state word. It recognises two exceptions: the software emulation trap and the instruction translation miss. When either one is present, the block issues a one-cycle redirect pulse with the new fetch address. It also registers the return address, the saved status word and the machine state word to be installed on entry.

The emulation trap covers every instruction that the core does not implement, and this includes all floating-point instructions. It also covers special-register moves that name a register with no implementation. For a register that is unimplemented but lives off the core, the trap is gated by bit 0 of the register number and by the privilege bit. A translation miss is raised only while instruction relocation is on. The miss outranks the emulation trap, because the fetch failed before decode took place. The pipeline, the translation table and the return-from-exception path live outside this block, and reach it only as input signals.

Top module: `exc_entry_unit`

## Requirements
- R1: An executing instruction (`dec_valid`=1) flagged unimplemented or illegal (`dec_unimpl`=1, which includes every floating-point instruction) raises the emulation exception. With `dec_valid`=0 nothing is raised.
- R2: An executing special-register move (`dec_spr_op`=1) that names an unimplemented on-core register raises the emulation exception, whatever the value of register-number bit 0 (`dec_spr_n0`). The on-core flag has no effect when `dec_spr_op`=0.
- R3: An executing special-register move that names an unimplemented off-core register raises the emulation exception only when `dec_spr_n0`=0 or the privilege bit MSR[14] (1 = user) is 0.
- R4: The redirect address is the base ORed with the offset. The base is 0x00000000 when MSR[6] is 0 and 0xFFF00000 when MSR[6] is 1. The offset is 0x01000 for the emulation exception and 0x01100 for the translation miss.
- R5: A translation miss is raised only when `fetch_valid`=1, `xlat_hit`=0 and relocation bit MSR[5] is 1.
- R6: `srr0_o` receives `dec_pc` on an emulation exception and `fetch_ea` on a translation miss.
- R7: `srr1_o[15:0]` receives MSR[15:0]. `srr1_o[31:16]` is zero, except that bit 30 is set on a translation miss.
- R8: The new MSR keeps bit 6 and bit 12 (machine-check enable). Bit 0 (little-endian mode) takes the value of MSR[16], and every other bit is 0.
- R9: When both exceptions are present in the same cycle, the translation miss is taken: the cause is the miss, and the vector and saved address are those of the miss.
- R10: All results are registered. They appear in the cycle after the clock edge that samples the condition. `redirect_o` is high for exactly one cycle per exception. `cause_o` is 1 for emulation, 2 for a miss, and 0 otherwise. `srr0_o`, `srr1_o`, `msr_o` and `redirect_pc_o` hold their values when no exception is taken.
- R11: While `rst` is high, every output is 0 and any exception condition that is present is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction executes this cycle |
| dec_unimpl | input | 1 | Instruction is unimplemented, illegal or floating-point |
| dec_spr_op | input | 1 | Instruction is a move to or from a special register |
| dec_spr_oncore_unimpl | input | 1 | Named special register is on-core and unimplemented |
| dec_spr_offcore_unimpl | input | 1 | Named special register is off-core and unimplemented |
| dec_spr_n0 | input | 1 | Bit 0 of the special-register number |
| dec_pc | input | 32 | Effective address of the executing instruction |
| fetch_valid | input | 1 | A fetch is attempted this cycle |
| fetch_ea | input | 32 | Effective address of the fetch |
| xlat_hit | input | 1 | Translation found for the fetch page |
| msr_i | input | 32 | Current machine state word |
| redirect_o | output | 1 | One-cycle flush and redirect pulse |
| redirect_pc_o | output | 32 | New fetch address |
| cause_o | output | 2 | 0 none, 1 emulation, 2 translation miss |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved status word |
| msr_o | output | 32 | Machine state word installed on entry |

## Verification
Every result of this block has one register between input and output. So a condition driven before a rising edge shows up on `redirect_o`, `cause_o`, `redirect_pc_o`, `srr0_o`, `srr1_o` and `msr_o` after that single edge, and the pulse drops after the next edge. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. After a taken exception it drives one idle cycle, to confirm that the pulse has ended and that the saved registers hold.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN = 32;
    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_EMUL  = 2'd1,
        CAUSE_XMISS = 2'd2
    } cause_e;

    // machine state bit positions (little-endian index)
    localparam int MSR_LE_B  = 0;
    localparam int MSR_IR_B  = 5;
    localparam int MSR_IP_B  = 6;
    localparam int MSR_ME_B  = 12;
    localparam int MSR_PR_B  = 14;
    localparam int MSR_ILE_B = 16;

    localparam int    SRR1_COPY_W      = 16;
    localparam int    SRR1_MISS_FLAG_B = 30;
    localparam word_t VEC_EMUL_OFF     = 32'h0000_1000;
    localparam word_t VEC_XMISS_OFF    = 32'h0000_1100;
    localparam word_t VEC_BASE_HIGH    = 32'hFFF0_0000;

    typedef struct packed {
        logic executes;
        logic unimpl;
        logic spr_op;
        logic spr_on_unimpl;
        logic spr_off_unimpl;
        logic spr_n0;
    } dec_info_t;

    typedef struct packed {
        cause_e cause;
        word_t  ret_addr;
        word_t  saved_stat;
        word_t  new_msr;
        word_t  target;
    } frame_t;

    function automatic word_t vec_base(input logic ip, input word_t high_base);
        return ip ? high_base : '0;
    endfunction

endpackage

// File: rtl/exc_cond_detect.sv
module exc_cond_detect
    import exc_entry_pkg::*;
(
    input  dec_info_t dec,
    input  word_t     pc,
    input  logic      fetch_valid,
    input  word_t     fetch_ea,
    input  logic      xlat_hit,
    input  logic      msr_ir,
    input  logic      msr_pr,
    output cause_e    cause,
    output word_t     ret_addr
);
    logic emul_hit;
    logic miss_hit;
    logic spr_trap;

    always_comb begin
        spr_trap = dec.spr_op &&
                   (dec.spr_on_unimpl ||
                    (dec.spr_off_unimpl && (!dec.spr_n0 || !msr_pr)));
        emul_hit = dec.executes && (dec.unimpl || spr_trap);
        miss_hit = fetch_valid && msr_ir && !xlat_hit;
    end

    always_comb begin
        if (miss_hit) begin
            cause    = CAUSE_XMISS;
            ret_addr = fetch_ea;
        end else if (emul_hit) begin
            cause    = CAUSE_EMUL;
            ret_addr = pc;
        end else begin
            cause    = CAUSE_NONE;
            ret_addr = '0;
        end
    end
endmodule

// File: rtl/exc_frame_build.sv
module exc_frame_build
    import exc_entry_pkg::*;
#(
    parameter word_t OFF_EMUL  = VEC_EMUL_OFF,
    parameter word_t OFF_XMISS = VEC_XMISS_OFF,
    parameter word_t BASE_HIGH = VEC_BASE_HIGH
) (
    input  cause_e                 cause,
    input  logic [SRR1_COPY_W-1:0] msr_low,
    input  logic                   msr_ile,
    output word_t                  saved_stat,
    output word_t                  new_msr,
    output word_t                  target
);
    localparam int KEEP_IP = MSR_IP_B;
    localparam int KEEP_ME = MSR_ME_B;

    logic is_miss;
    assign is_miss = (cause == CAUSE_XMISS);

    // saved status word, built bit by bit
    for (genvar i = 0; i < XLEN; i++) begin : g_srr1
        if (i < SRR1_COPY_W) begin : g_copy
            assign saved_stat[i] = msr_low[i];
        end else if (i == SRR1_MISS_FLAG_B) begin : g_flag
            assign saved_stat[i] = is_miss;
        end else begin : g_zero
            assign saved_stat[i] = 1'b0;
        end
    end

    // new machine state word
    for (genvar i = 0; i < XLEN; i++) begin : g_msr
        if (i == KEEP_IP || i == KEEP_ME) begin : g_keep
            assign new_msr[i] = msr_low[i];
        end else if (i == MSR_LE_B) begin : g_le
            assign new_msr[i] = msr_ile;
        end else begin : g_clr
            assign new_msr[i] = 1'b0;
        end
    end

    always_comb begin
        target = vec_base(msr_low[MSR_IP_B], BASE_HIGH) |
                 (is_miss ? OFF_XMISS : OFF_EMUL);
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter word_t OFF_EMUL  = VEC_EMUL_OFF,
    parameter word_t OFF_XMISS = VEC_XMISS_OFF,
    parameter word_t BASE_HIGH = VEC_BASE_HIGH
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dec_valid,
    input  logic        dec_unimpl,
    input  logic        dec_spr_op,
    input  logic        dec_spr_oncore_unimpl,
    input  logic        dec_spr_offcore_unimpl,
    input  logic        dec_spr_n0,
    input  logic [31:0] dec_pc,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_ea,
    input  logic        xlat_hit,
    input  logic [31:0] msr_i,
    output logic        redirect_o,
    output logic [31:0] redirect_pc_o,
    output logic [1:0]  cause_o,
    output logic [31:0] srr0_o,
    output logic [31:0] srr1_o,
    output logic [31:0] msr_o
);
    dec_info_t dec;
    frame_t    frame;
    logic      unused_msr_hi;

    assign unused_msr_hi = ^msr_i[XLEN-1:MSR_ILE_B+1];

    always_comb begin
        dec.executes       = dec_valid;
        dec.unimpl         = dec_unimpl;
        dec.spr_op         = dec_spr_op;
        dec.spr_on_unimpl  = dec_spr_oncore_unimpl;
        dec.spr_off_unimpl = dec_spr_offcore_unimpl;
        dec.spr_n0         = dec_spr_n0;
    end

    exc_cond_detect u_detect (
        .dec         (dec),
        .pc          (dec_pc),
        .fetch_valid (fetch_valid),
        .fetch_ea    (fetch_ea),
        .xlat_hit    (xlat_hit),
        .msr_ir      (msr_i[MSR_IR_B]),
        .msr_pr      (msr_i[MSR_PR_B]),
        .cause       (frame.cause),
        .ret_addr    (frame.ret_addr)
    );

    exc_frame_build #(
        .OFF_EMUL  (OFF_EMUL),
        .OFF_XMISS (OFF_XMISS),
        .BASE_HIGH (BASE_HIGH)
    ) u_frame (
        .cause      (frame.cause),
        .msr_low    (msr_i[SRR1_COPY_W-1:0]),
        .msr_ile    (msr_i[MSR_ILE_B]),
        .saved_stat (frame.saved_stat),
        .new_msr    (frame.new_msr),
        .target     (frame.target)
    );

    logic   taken;
    cause_e cause_q;
    assign taken = (frame.cause != CAUSE_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_o    <= 1'b0;
            cause_q       <= CAUSE_NONE;
            redirect_pc_o <= '0;
            srr0_o        <= '0;
            srr1_o        <= '0;
            msr_o         <= '0;
        end else begin
            redirect_o <= taken;
            cause_q    <= frame.cause;
            if (taken) begin
                redirect_pc_o <= frame.target;
                srr0_o        <= frame.ret_addr;
                srr1_o        <= frame.saved_stat;
                msr_o         <= frame.new_msr;
            end
        end
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk
    import exc_entry_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        dec_valid,
    input logic        dec_unimpl,
    input logic        dec_spr_op,
    input logic        dec_spr_oncore_unimpl,
    input logic        dec_spr_offcore_unimpl,
    input logic        dec_spr_n0,
    input logic [31:0] dec_pc,
    input logic        fetch_valid,
    input logic [31:0] fetch_ea,
    input logic        xlat_hit,
    input logic [31:0] msr_i,
    input logic        redirect_o,
    input logic [31:0] redirect_pc_o,
    input logic [1:0]  cause_o,
    input logic [31:0] srr0_o,
    input logic [31:0] srr1_o,
    input logic [31:0] msr_o
);
    assert_unimpl_traps_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(dec_valid && dec_unimpl) |-> redirect_o)
        else $error("R1 unimplemented instruction not trapped");

    assert_oncore_traps_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(dec_valid && dec_spr_op && dec_spr_oncore_unimpl) |-> redirect_o)
        else $error("R2 on-core register move not trapped");

    assert_offcore_guard_R3: assert property (@(posedge clk) disable iff (rst)
        (cause_o == 2'd1) && $past(!dec_unimpl && !dec_spr_oncore_unimpl)
        |-> $past(!dec_spr_n0 || !msr_i[MSR_PR_B]))
        else $error("R3 off-core trap without guard");

    assert_vector_R4: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> redirect_pc_o[19:0] == ((cause_o == 2'd2) ? 20'h01100 : 20'h01000))
        else $error("R4 wrong vector offset");

    assert_miss_needs_ir_R5: assert property (@(posedge clk) disable iff (rst)
        (cause_o == 2'd2) |-> $past(msr_i[MSR_IR_B] && fetch_valid && !xlat_hit))
        else $error("R5 miss without relocation");

    assert_srr0_R6: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> srr0_o == ((cause_o == 2'd2) ? $past(fetch_ea) : $past(dec_pc)))
        else $error("R6 wrong saved address");

    assert_srr1_R7: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (srr1_o[15:0] == $past(msr_i[15:0])) && (srr1_o[29:16] == '0) &&
                       (srr1_o[31] == 1'b0))
        else $error("R7 saved status malformed");

    assert_new_msr_R8: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (msr_o[MSR_IP_B] == $past(msr_i[MSR_IP_B])) &&
                       (msr_o[MSR_ME_B] == $past(msr_i[MSR_ME_B])) &&
                       (msr_o[MSR_LE_B] == $past(msr_i[MSR_ILE_B])) &&
                       ($countones(msr_o) <= 3))
        else $error("R8 new machine state malformed");

    assert_priority_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(fetch_valid && !xlat_hit && msr_i[MSR_IR_B]) |-> cause_o == 2'd2)
        else $error("R9 miss lost priority");

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !redirect_o |-> $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o) && cause_o == 2'd0)
        else $error("R10 state changed without exception");

    assert_reset_R11: assert property (@(posedge clk)
        $past(rst) |-> !redirect_o && cause_o == 2'd0)
        else $error("R11 output active after reset");
endmodule

bind exc_entry_unit exc_entry_unit_chk u_chk (
    .clk                    (clk),
    .rst                    (rst),
    .dec_valid              (dec_valid),
    .dec_unimpl             (dec_unimpl),
    .dec_spr_op             (dec_spr_op),
    .dec_spr_oncore_unimpl  (dec_spr_oncore_unimpl),
    .dec_spr_offcore_unimpl (dec_spr_offcore_unimpl),
    .dec_spr_n0             (dec_spr_n0),
    .dec_pc                 (dec_pc),
    .fetch_valid            (fetch_valid),
    .fetch_ea               (fetch_ea),
    .xlat_hit               (xlat_hit),
    .msr_i                  (msr_i),
    .redirect_o             (redirect_o),
    .redirect_pc_o          (redirect_pc_o),
    .cause_o                (cause_o),
    .srr0_o                 (srr0_o),
    .srr1_o                 (srr1_o),
    .msr_o                  (msr_o)
);

// File: tb/exc_entry_unit_bench.sv
`timescale 1ns/1ps
module exc_entry_unit_bench;

    localparam logic [31:0] M_LE  = 32'h0000_0001;
    localparam logic [31:0] M_RI  = 32'h0000_0002;
    localparam logic [31:0] M_IR  = 32'h0000_0020;
    localparam logic [31:0] M_IP  = 32'h0000_0040;
    localparam logic [31:0] M_ME  = 32'h0000_1000;
    localparam logic [31:0] M_PR  = 32'h0000_4000;
    localparam logic [31:0] M_EE  = 32'h0000_8000;
    localparam logic [31:0] M_ILE = 32'h0001_0000;

    typedef struct packed {
        logic        v;
        logic        un;
        logic        spr;
        logic        on;
        logic        off;
        logic        n0;
        logic        fv;
        logic        hit;
        logic [31:0] msr;
        logic [31:0] pc;
        logic [31:0] fea;
        logic [1:0]  cause;
        logic [31:0] tgt;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // idle fetch that translates: nothing
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, M_IR|M_PR, 32'h100, 32'h2000, 2'd0, 32'h0},
        // R1 unimplemented instruction, low base
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, M_ME|M_EE|M_ILE|M_RI, 32'h104, 32'h0, 2'd1, 32'h0000_1000},
        // R4 high base
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, M_IP|M_PR|M_LE|32'hFFFE_0000, 32'h108, 32'h0, 2'd1, 32'hFFF0_1000},
        // R2 on-core, n0=1, user mode
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1, M_PR, 32'h10C, 32'h0, 2'd1, 32'h0000_1000},
        // R3 off-core, n0=1, user mode: no trap
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1, M_PR, 32'h110, 32'h0, 2'd0, 32'h0},
        // R3 off-core, n0=0, user mode
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1, M_PR|M_EE, 32'h114, 32'h0, 2'd1, 32'h0000_1000},
        // R3 off-core, n0=1, supervisor, high base
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1, M_IP|M_ILE, 32'h118, 32'h0, 2'd1, 32'hFFF0_1000},
        // R2 on-core flag without a register move: no trap
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1, M_PR, 32'h11C, 32'h0, 2'd0, 32'h0},
        // R5 miss with relocation on
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, M_IR|M_ME, 32'h120, 32'h0004_5678, 2'd2, 32'h0000_1100},
        // R5 miss with relocation off: nothing
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, M_ME, 32'h124, 32'h0004_9000, 2'd0, 32'h0},
        // R5 relocation on, translation hit: nothing
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, M_IR, 32'h128, 32'h0004_A000, 2'd0, 32'h0},
        // R9 both present: miss wins, high base
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, M_IR|M_IP|M_ME|M_ILE, 32'h12C, 32'h0007_0000, 2'd2, 32'hFFF0_1100},
        // R1 instruction not executing: nothing
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, M_PR, 32'h130, 32'h0, 2'd0, 32'h0},
        // R5 no fetch attempted: nothing
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, M_IR, 32'h134, 32'h0008_0000, 2'd0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        dec_valid, dec_unimpl, dec_spr_op, dec_spr_oncore_unimpl;
    logic        dec_spr_offcore_unimpl, dec_spr_n0, fetch_valid, xlat_hit;
    logic [31:0] dec_pc, fetch_ea, msr_i;
    logic        redirect_o;
    logic [31:0] redirect_pc_o, srr0_o, srr1_o, msr_o;
    logic [1:0]  cause_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] e_srr0 = '0, e_srr1 = '0, e_msr = '0, e_pc = '0;

    always #2.5 clk = ~clk;

    exc_entry_unit u_exc_entry_unit (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_unimpl(dec_unimpl), .dec_spr_op(dec_spr_op),
        .dec_spr_oncore_unimpl(dec_spr_oncore_unimpl),
        .dec_spr_offcore_unimpl(dec_spr_offcore_unimpl),
        .dec_spr_n0(dec_spr_n0), .dec_pc(dec_pc),
        .fetch_valid(fetch_valid), .fetch_ea(fetch_ea), .xlat_hit(xlat_hit),
        .msr_i(msr_i),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .cause_o(cause_o),
        .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_srr1(input logic [31:0] m, input logic miss);
        return {16'h0, m[15:0]} | (miss ? 32'h4000_0000 : 32'h0);
    endfunction

    function automatic logic [31:0] exp_msr(input logic [31:0] m);
        return (m & (M_IP | M_ME)) | {31'h0, m[16]};
    endfunction

    task automatic drive(input vec_t v);
        dec_valid = v.v;  dec_unimpl = v.un; dec_spr_op = v.spr;
        dec_spr_oncore_unimpl = v.on; dec_spr_offcore_unimpl = v.off;
        dec_spr_n0 = v.n0; fetch_valid = v.fv; xlat_hit = v.hit;
        msr_i = v.msr; dec_pc = v.pc; fetch_ea = v.fea;
    endtask

    task automatic idle();
        dec_valid = 0; dec_unimpl = 0; dec_spr_op = 0; dec_spr_oncore_unimpl = 0;
        dec_spr_offcore_unimpl = 0; dec_spr_n0 = 0; fetch_valid = 0; xlat_hit = 1;
        msr_i = '0; dec_pc = '0; fetch_ea = '0;
    endtask

    task automatic check_outputs(input string req, input logic [1:0] ec);
        chk({req, " R10 cause"}, {30'h0, cause_o}, {30'h0, ec});
        chk({req, " R10 redirect"}, {31'h0, redirect_o}, {31'h0, ec != 2'd0});
        chk({req, " R4 target"}, redirect_pc_o, e_pc);
        chk({req, " R6 srr0"}, srr0_o, e_srr0);
        chk({req, " R7 srr1"}, srr1_o, e_srr1);
        chk({req, " R8 msr"}, msr_o, e_msr);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check_outputs("R11 reset", 2'd0);

        // R11 condition present during reset is ignored
        drive(VECS[1]);
        @(posedge clk); @(negedge clk);
        check_outputs("R11 ignored in reset", 2'd0);
        rst = 0;
        idle();
        @(posedge clk); @(negedge clk);
        check_outputs("R11 after release", 2'd0);

        // table walk: each result one edge after its stimulus
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(posedge clk); @(negedge clk);
            if (VECS[i].cause != 2'd0) begin
                e_pc   = VECS[i].tgt;
                e_srr0 = (VECS[i].cause == 2'd2) ? VECS[i].fea : VECS[i].pc;
                e_srr1 = exp_srr1(VECS[i].msr, VECS[i].cause == 2'd2);
                e_msr  = exp_msr(VECS[i].msr);
            end
            check_outputs($sformatf("vec%0d", i), VECS[i].cause);
        end

        // R10 pulse lasts one cycle, saved state holds on idle
        drive(VECS[5]);
        @(posedge clk); @(negedge clk);
        e_pc = VECS[5].tgt; e_srr0 = VECS[5].pc;
        e_srr1 = exp_srr1(VECS[5].msr, 1'b0); e_msr = exp_msr(VECS[5].msr);
        check_outputs("R10 pulse on", 2'd1);
        idle();
        @(posedge clk); @(negedge clk);
        check_outputs("R10 pulse off", 2'd0);

        // R10 back-to-back exceptions each pulse
        drive(VECS[8]);
        @(posedge clk); @(negedge clk);
        e_pc = VECS[8].tgt; e_srr0 = VECS[8].fea;
        e_srr1 = exp_srr1(VECS[8].msr, 1'b1); e_msr = exp_msr(VECS[8].msr);
        check_outputs("R10 back1", 2'd2);
        drive(VECS[3]);
        @(posedge clk); @(negedge clk);
        e_pc = VECS[3].tgt; e_srr0 = VECS[3].pc;
        e_srr1 = exp_srr1(VECS[3].msr, 1'b0); e_msr = exp_msr(VECS[3].msr);
        check_outputs("R10 back2", 2'd1);
        idle();
        @(posedge clk); @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule